// File: doc/BRIEF.md
# Flush-to-Zero Single-Precision Divider

This block divides two IEEE-754 single-precision operands over a fixed number of clock cycles. It is built for an execution unit that issues at most one divide every sixteen cycles and needs the quotient exactly seventeen cycles after issue. The block does not support subnormals. A subnormal operand is treated as zero. A quotient too small to be a normal number is returned as a signed zero. Each of these two events raises its own flag. Any invalid operation returns the all-ones bit pattern.

An operation is accepted on a rising edge where `issue_i` is high and the unit is idle. The operands, the rounding mode and the guard bit are captured on that edge. The finite-state machine has four states. The states are `ST_IDLE`, `ST_PREP`, `ST_DIV` and `ST_ROUND`, with these transitions:

- idle to prep: an issue is accepted.
- prep to div: operands are unpacked, flushed and classified, and the remainder is seeded.
- div to div: two quotient bits are produced per cycle by restoring subtraction.
- div to round: the last quotient bits have been produced.
- round to idle: the quotient is rounded and packed into a short retirement pipe.

The retirement pipe delivers the result with the fixed latency. Because of this pipe, the next divide can start while the previous result is still on its way out. The guard bit controls write-back. When the guard is clear, the quotient is still produced, but the write-enable stays low and no flag leaves the block.

Top module: `fdz_div`

## Requirements
- R1: Out of reset, `busy_o`, `done_o`, `wr_en_o`, `q_o` and `flags_o` are all zero. For an issue accepted on edge k, `done_o` is high for exactly the one cycle after edge k+17. `q_o` holds the quotient only in that cycle and reads zero at all other times.
- R2: `busy_o` is high after the accepting edge and falls after edge k+15. While it is high, `issue_i` and the operand inputs are ignored. An issue held high is therefore accepted on edge k+16, and its result arrives at k+33.
- R3: Flag bit positions are: [0] inexact, [1] underflow, [2] overflow, [3] divide-by-zero, [4] invalid, [5] input flushed, [6] output flushed. `wr_en_o` equals `done_o` AND the captured guard bit. When the guard is 0, `flags_o` stays all zero.
- R4: Normal quotients are rounded by `rnd_i`: 0 nearest-even, 1 toward zero, 2 toward +infinity, 3 toward -infinity. Inexact (bit 0) is set whenever bits are discarded.
- R5: An operand with exponent field 0 and a nonzero fraction is replaced by zero before dividing, and bit 5 is set.
- R6: If the normalized quotient exponent before rounding falls below the smallest normal exponent, the result is a zero with the quotient's sign, and bits 6, 1 and 0 are set.
- R7: A finite nonzero dividend over a zero divisor (including a flushed divisor) gives infinity with the quotient's sign and sets bit 3.
- R8: A NaN operand, 0/0 or infinity/infinity gives 0xFFFFFFFF and sets bit 4.
- R9: When the rounded exponent overflows, the result is infinity for nearest, for up with positive sign, and for down with negative sign. Otherwise it is the largest finite value with the quotient's sign. Bits 2 and 0 are set.
- R10: 0/finite gives a signed zero, finite/infinity gives a signed zero, and infinity/finite gives a signed infinity, all with no flag. An exact normal quotient also raises no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_i | input | 1 | Request to start a divide |
| guard_i | input | 1 | Write-back guard, captured at issue |
| rnd_i | input | 2 | Rounding mode, captured at issue |
| a_i | input | 32 | Dividend |
| b_i | input | 32 | Divisor |
| busy_o | output | 1 | Unit cannot accept an issue |
| done_o | output | 1 | Result-valid strobe |
| wr_en_o | output | 1 | Write-back enable (done and guard) |
| q_o | output | 32 | Quotient |
| flags_o | output | 7 | Exception flags, layout in R3 |

## Verification
The assertions assume that `rst_n` is asserted from time zero until the inputs are defined. They also assume that `issue_i`, `guard_i`, `rnd_i` and the operands carry known values on every edge. They do not assume that issues respect the recovery window: refusal while busy is part of the behaviour being checked. The stimulus changes inputs only on falling edges. It always drives defined operands and holds `issue_i` through a busy window to exercise refusal.

// File: rtl/fdz_pkg.sv
package fdz_pkg;
    localparam int W     = 32;
    localparam int EW    = 8;
    localparam int MW    = 23;
    localparam int FW    = MW + 1;     // significand with hidden one
    localparam int QW    = FW + 2;     // quotient bits: 24 kept + 1 normalise + 1 round
    localparam int RW    = FW + 2;     // remainder width
    localparam int NFLAG = 7;

    localparam int FL_NX  = 0;
    localparam int FL_UF  = 1;
    localparam int FL_OF  = 2;
    localparam int FL_DZ  = 3;
    localparam int FL_NV  = 4;
    localparam int FL_IFZ = 5;
    localparam int FL_OFZ = 6;

    typedef enum logic [1:0] {
        RM_NEAR = 2'd0,
        RM_ZERO = 2'd1,
        RM_UP   = 2'd2,
        RM_DOWN = 2'd3
    } rmode_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PREP,
        ST_DIV,
        ST_ROUND
    } st_t;

    typedef enum logic [2:0] {
        SP_NONE,
        SP_NAN,
        SP_DZ,
        SP_INF,
        SP_ZERO
    } spec_t;

    typedef struct packed {
        logic [W-1:0]     q;
        logic [NFLAG-1:0] fl;
        logic             g;
        logic             v;
    } res_t;
endpackage

// File: rtl/fdz_unpack.sv
module fdz_unpack
    import fdz_pkg::*;
(
    input  logic [W-1:0]  x,
    output logic          sgn,
    output logic [EW-1:0] expo,
    output logic [FW-1:0] man,
    output logic          is_zero,
    output logic          is_inf,
    output logic          is_nan,
    output logic          flushed
);
    logic [EW-1:0] ef;
    logic [MW-1:0] fr;

    assign ef      = x[W-2:MW];
    assign fr      = x[MW-1:0];
    assign sgn     = x[W-1];
    assign expo    = ef;
    assign man     = {1'b1, fr};
    // zero exponent field: true zero or flushed subnormal
    assign is_zero = (ef == '0);
    assign flushed = (ef == '0) && (fr != '0);
    assign is_inf  = (ef == '1) && (fr == '0);
    assign is_nan  = (ef == '1) && (fr != '0);
endmodule

// File: rtl/fdz_iter.sv
module fdz_iter
    import fdz_pkg::*;
#(
    parameter int QPC = 2
) (
    input  logic [RW-1:0]  rem_i,
    input  logic [FW-1:0]  div_i,
    output logic [RW-1:0]  rem_o,
    output logic [QPC-1:0] bits_o
);
    logic [RW-1:0] r [QPC+1];

    assign r[0] = rem_i;

    for (genvar i = 0; i < QPC; i++) begin : g_step
        logic [RW:0] diff;
        logic        ge;
        assign diff = {1'b0, r[i]} - {{(RW+1-FW){1'b0}}, div_i};
        assign ge   = ~diff[RW];
        assign r[i+1] = (ge ? diff[RW-1:0] : r[i]) << 1;
        assign bits_o[QPC-1-i] = ge;
    end

    assign rem_o = r[QPC];
endmodule

// File: rtl/fdz_round.sv
module fdz_round
    import fdz_pkg::*;
(
    input  logic             sgn,
    input  logic signed [9:0] e_pre,
    input  logic [QW-1:0]    qraw,
    input  logic             rem_nz,
    input  rmode_t           rm,
    input  spec_t            sp,
    input  logic             in_flush,
    output logic [W-1:0]     q,
    output logic [NFLAG-1:0] fl
);
    logic [FW-1:0]    m;
    logic             rb, sb, inc, big;
    logic signed [9:0] e_n, e_r;
    logic [FW:0]      sum;
    logic [MW-1:0]    frac;

    always_comb begin
        if (qraw[QW-1]) begin
            m   = qraw[QW-1:2];
            rb  = qraw[1];
            sb  = qraw[0] | rem_nz;
            e_n = e_pre + 10'sd1;
        end else begin
            m   = qraw[QW-2:1];
            rb  = qraw[0];
            sb  = rem_nz;
            e_n = e_pre;
        end

        unique case (rm)
            RM_NEAR: inc = rb & (sb | m[0]);
            RM_ZERO: inc = 1'b0;
            RM_UP:   inc = ~sgn & (rb | sb);
            RM_DOWN: inc = sgn & (rb | sb);
        endcase

        sum  = {1'b0, m} + {{FW{1'b0}}, inc};
        frac = sum[FW] ? sum[MW:1] : sum[MW-1:0];
        e_r  = sum[FW] ? e_n + 10'sd1 : e_n;
        big  = (rm == RM_NEAR) || (rm == RM_UP && !sgn) || (rm == RM_DOWN && sgn);

        q  = '0;
        fl = '0;
        fl[FL_IFZ] = in_flush;
        unique case (sp)
            SP_NAN: begin
                q = '1;
                fl[FL_NV] = 1'b1;
            end
            SP_DZ: begin
                q = {sgn, {EW{1'b1}}, {MW{1'b0}}};
                fl[FL_DZ] = 1'b1;
            end
            SP_INF:  q = {sgn, {EW{1'b1}}, {MW{1'b0}}};
            SP_ZERO: q = {sgn, {(W-1){1'b0}}};
            default: begin
                if (e_n < 10'sd1) begin
                    q = {sgn, {(W-1){1'b0}}};
                    fl[FL_OFZ] = 1'b1;
                    fl[FL_UF]  = 1'b1;
                    fl[FL_NX]  = 1'b1;
                end else if (e_r >= 10'sd255) begin
                    fl[FL_OF] = 1'b1;
                    fl[FL_NX] = 1'b1;
                    q = big ? {sgn, {EW{1'b1}}, {MW{1'b0}}}
                            : {sgn, {(EW-1){1'b1}}, 1'b0, {MW{1'b1}}};
                end else begin
                    q = {sgn, e_r[EW-1:0], frac};
                    fl[FL_NX] = rb | sb;
                end
            end
        endcase
    end
endmodule

// File: rtl/fdz_div.sv
module fdz_div
    import fdz_pkg::*;
#(
    parameter int LAT = 17,   // issue edge to result-valid edge
    parameter int QPC = 2     // quotient bits per cycle, must divide QW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_i,
    input  logic             guard_i,
    input  logic [1:0]       rnd_i,
    input  logic [W-1:0]     a_i,
    input  logic [W-1:0]     b_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             wr_en_o,
    output logic [W-1:0]     q_o,
    output logic [NFLAG-1:0] flags_o
);
    localparam int ITERS = QW / QPC;
    localparam int ITW   = $clog2(ITERS);
    localparam int PIPE  = LAT - ITERS - 1;
    localparam logic [ITW-1:0] LAST = ITW'(ITERS - 1);

    st_t st, st_n;

    logic [W-1:0]     opa_q, opb_q;
    rmode_t           rm_q;
    logic             g_q, sgn_q, ifz_q;
    logic signed [9:0] epre_q;
    spec_t            sp_q, sp_c;
    logic [RW-1:0]    rem_q, rem_n;
    logic [FW-1:0]    mb_q;
    logic [QW-1:0]    quo_q;
    logic [QPC-1:0]   qbits;
    logic [ITW-1:0]   it_q;

    logic          as, bs, az, bz, ai, bi, an, bn, af, bf;
    logic [EW-1:0] ae, be;
    logic [FW-1:0] am, bm;

    logic [W-1:0]     rq;
    logic [NFLAG-1:0] rfl;

    res_t stg [PIPE];

    fdz_unpack u_ua (.x(opa_q), .sgn(as), .expo(ae), .man(am), .is_zero(az),
                     .is_inf(ai), .is_nan(an), .flushed(af));
    fdz_unpack u_ub (.x(opb_q), .sgn(bs), .expo(be), .man(bm), .is_zero(bz),
                     .is_inf(bi), .is_nan(bn), .flushed(bf));

    fdz_iter #(.QPC(QPC)) u_it (.rem_i(rem_q), .div_i(mb_q), .rem_o(rem_n), .bits_o(qbits));

    fdz_round u_rd (.sgn(sgn_q), .e_pre(epre_q), .qraw(quo_q), .rem_nz(|rem_q),
                    .rm(rm_q), .sp(sp_q), .in_flush(ifz_q), .q(rq), .fl(rfl));

    // operand classification, priority: invalid, inf dividend, zero divisor, zero result
    always_comb begin
        if (an || bn || (ai && bi) || (az && bz)) sp_c = SP_NAN;
        else if (ai)                              sp_c = SP_INF;
        else if (bz)                              sp_c = SP_DZ;
        else if (az || bi)                        sp_c = SP_ZERO;
        else                                      sp_c = SP_NONE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_n;
    end

    always_comb begin
        st_n = st;
        unique case (st)
            ST_IDLE:  if (issue_i) st_n = ST_PREP;
            ST_PREP:  st_n = ST_DIV;
            ST_DIV:   if (it_q == LAST) st_n = ST_ROUND;
            ST_ROUND: st_n = ST_IDLE;
            default:  st_n = ST_IDLE;
        endcase
    end

    assign busy_o = (st != ST_IDLE);

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opa_q  <= '0;
            opb_q  <= '0;
            rm_q   <= RM_NEAR;
            g_q    <= 1'b0;
            sgn_q  <= 1'b0;
            ifz_q  <= 1'b0;
            epre_q <= '0;
            sp_q   <= SP_NONE;
            rem_q  <= '0;
            mb_q   <= '0;
            quo_q  <= '0;
            it_q   <= '0;
        end else begin
            unique case (st)
                ST_IDLE: if (issue_i) begin
                    opa_q <= a_i;
                    opb_q <= b_i;
                    rm_q  <= rmode_t'(rnd_i);
                    g_q   <= guard_i;
                end
                ST_PREP: begin
                    sgn_q  <= as ^ bs;
                    ifz_q  <= af | bf;
                    sp_q   <= sp_c;
                    epre_q <= $signed({2'b00, ae}) - $signed({2'b00, be}) + 10'sd126;
                    rem_q  <= {{(RW-FW){1'b0}}, am};
                    mb_q   <= bm;
                    quo_q  <= '0;
                    it_q   <= '0;
                end
                ST_DIV: begin
                    rem_q <= rem_n;
                    quo_q <= {quo_q[QW-QPC-1:0], qbits};
                    it_q  <= it_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // retirement pipe and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg[0] <= '0;
        end else begin
            stg[0].v  <= (st == ST_ROUND);
            stg[0].g  <= g_q;
            stg[0].q  <= rq;
            stg[0].fl <= rfl;
        end
    end

    for (genvar i = 1; i < PIPE; i++) begin : g_pipe
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= '0;
            else        stg[i] <= stg[i-1];
        end
    end

    assign done_o  = stg[PIPE-1].v;
    assign wr_en_o = stg[PIPE-1].v & stg[PIPE-1].g;
    assign q_o     = stg[PIPE-1].v ? stg[PIPE-1].q : '0;
    assign flags_o = wr_en_o ? stg[PIPE-1].fl : '0;

    assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_busy_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(issue_i));
    assert_wren_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> done_o);
    assert_flags_guard_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o != '0) |-> wr_en_o);
    assert_oflush_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flags_o[FL_OFZ] |-> (q_o[W-2:0] == '0));
    assert_dz_inf_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flags_o[FL_DZ] |-> (q_o[W-2:0] == 31'h7F800000));
    assert_invalid_ones_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flags_o[FL_NV] |-> (q_o == 32'hFFFFFFFF));
    assert_ovf_sat_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flags_o[FL_OF] |-> (q_o[W-2:0] == 31'h7F800000 || q_o[W-2:0] == 31'h7F7FFFFF));
endmodule

// File: tb/tb_fdz_div.sv
module tb_fdz_div;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_i = 1'b0;
    logic        guard_i = 1'b0;
    logic [1:0]  rnd_i = 2'd0;
    logic [31:0] a_i = '0;
    logic [31:0] b_i = '0;
    logic        busy_o, done_o, wr_en_o;
    logic [31:0] q_o;
    logic [6:0]  flags_o;

    int errs = 0;
    int checks = 0;

    always #5 clk = ~clk;

    fdz_div dut (.clk(clk), .rst_n(rst_n), .issue_i(issue_i), .guard_i(guard_i),
                 .rnd_i(rnd_i), .a_i(a_i), .b_i(b_i), .busy_o(busy_o), .done_o(done_o),
                 .wr_en_o(wr_en_o), .q_o(q_o), .flags_o(flags_o));

    // {req, a, b, mode, quotient, flags}
    localparam int NV = 26;
    localparam logic [108:0] VEC [NV] = '{
        {4'd4,  32'hC0400000, 32'h3F800000, 2'd0, 32'hC0400000, 7'h00}, // R4
        {4'd4,  32'h40400000, 32'hC0400000, 2'd0, 32'hBF800000, 7'h00}, // R4
        {4'd4,  32'h40400000, 32'h00800000, 2'd0, 32'h7F400000, 7'h00}, // R4
        {4'd5,  32'h40400000, 32'h00400000, 2'd0, 32'h7F800000, 7'h28}, // R5 R7
        {4'd4,  32'h00C00000, 32'h80800000, 2'd0, 32'hBFC00000, 7'h00}, // R4
        {4'd8,  32'h7F800000, 32'hFF800000, 2'd0, 32'hFFFFFFFF, 7'h10}, // R8
        {4'd10, 32'h7F7FFFFF, 32'h7F7FFFFF, 2'd0, 32'h3F800000, 7'h00}, // R10
        {4'd10, 32'h00800000, 32'h00800000, 2'd0, 32'h3F800000, 7'h00}, // R10
        {4'd7,  32'h40400000, 32'h00000000, 2'd0, 32'h7F800000, 7'h08}, // R7
        {4'd4,  32'h3F800000, 32'h40400000, 2'd0, 32'h3EAAAAAB, 7'h01}, // R4
        {4'd4,  32'h3F800000, 32'h40400000, 2'd1, 32'h3EAAAAAA, 7'h01}, // R4
        {4'd4,  32'h3F800000, 32'h40400000, 2'd2, 32'h3EAAAAAB, 7'h01}, // R4
        {4'd4,  32'hBF800000, 32'h40400000, 2'd3, 32'hBEAAAAAB, 7'h01}, // R4
        {4'd4,  32'hBF800000, 32'h40400000, 2'd2, 32'hBEAAAAAA, 7'h01}, // R4
        {4'd6,  32'h00800000, 32'h40000000, 2'd0, 32'h00000000, 7'h43}, // R6
        {4'd6,  32'h80800000, 32'h40000000, 2'd0, 32'h80000000, 7'h43}, // R6
        {4'd9,  32'h7F7FFFFF, 32'h3F000000, 2'd0, 32'h7F800000, 7'h05}, // R9
        {4'd9,  32'h7F7FFFFF, 32'h3F000000, 2'd1, 32'h7F7FFFFF, 7'h05}, // R9
        {4'd9,  32'hFF7FFFFF, 32'h3F000000, 2'd2, 32'hFF7FFFFF, 7'h05}, // R9
        {4'd9,  32'hFF7FFFFF, 32'h3F000000, 2'd3, 32'hFF800000, 7'h05}, // R9
        {4'd8,  32'h00000000, 32'h00000000, 2'd0, 32'hFFFFFFFF, 7'h10}, // R8
        {4'd8,  32'h7FC00000, 32'h3F800000, 2'd0, 32'hFFFFFFFF, 7'h10}, // R8
        {4'd10, 32'h80000000, 32'h40400000, 2'd0, 32'h80000000, 7'h00}, // R10
        {4'd10, 32'h40400000, 32'h7F800000, 2'd0, 32'h00000000, 7'h00}, // R10
        {4'd10, 32'hFF800000, 32'h40400000, 2'd0, 32'hFF800000, 7'h00}, // R10
        {4'd5,  32'h00400000, 32'h40400000, 2'd0, 32'h00000000, 7'h20}  // R5
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic [1:0] rm,
                          input logic g, output int lat, output int ndone,
                          output logic [31:0] q, output logic [6:0] fl, output logic we);
        @(negedge clk);
        a_i = a; b_i = b; rnd_i = rm; guard_i = g; issue_i = 1'b1;
        @(negedge clk);
        issue_i = 1'b0;
        lat = -1; ndone = 0; q = '0; fl = '0; we = 1'b0;
        for (int n = 1; n <= 20; n++) begin
            @(negedge clk);
            if (done_o) begin
                ndone++;
                if (lat < 0) begin
                    lat = n; q = q_o; fl = flags_o; we = wr_en_o;
                end
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++; checks++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        int lat, nd;
        logic [31:0] q;
        logic [6:0] fl;
        logic we;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 R2 reset state
        chk(busy_o == 1'b0, "R2 reset busy", {31'b0, busy_o}, 32'h0);
        chk(done_o == 1'b0 && wr_en_o == 1'b0, "R1 reset strobes", {30'b0, done_o, wr_en_o}, 32'h0);
        chk(q_o == '0 && flags_o == '0, "R1 reset data", q_o | {25'b0, flags_o}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            logic [108:0] v;
            v = VEC[i];
            run_op(v[104:73], v[72:41], v[40:39], 1'b1, lat, nd, q, fl, we);
            chk(q == v[38:7], $sformatf("R%0d quotient vec %0d", v[108:105], i), q, v[38:7]);
            chk(fl == v[6:0], $sformatf("R%0d flags vec %0d", v[108:105], i), {25'b0, fl}, {25'b0, v[6:0]});
            chk(we == 1'b1, $sformatf("R3 wr_en vec %0d", i), {31'b0, we}, 32'h1);
            if (i == 0) begin
                chk(lat == 17, "R1 latency", lat, 17);
                chk(nd == 1, "R1 single strobe", nd, 1);
            end
        end

        // R3 guard clear: divide by zero would flag, but nothing leaves
        run_op(32'h40400000, 32'h00000000, 2'd0, 1'b0, lat, nd, q, fl, we);
        chk(lat == 17, "R3 guard-off latency", lat, 17);
        chk(we == 1'b0, "R3 guard-off wr_en", {31'b0, we}, 32'h0);
        chk(fl == '0, "R3 guard-off flags", {25'b0, fl}, 32'h0);

        // R2 issue held through the busy window: second op taken at edge k+16
        begin
            int d1, d2, nds;
            logic [31:0] q1, q2;
            logic b14, b15, qidle;
            d1 = -1; d2 = -1; nds = 0; q1 = '0; q2 = '0; b14 = 1'b0; b15 = 1'b1; qidle = 1'b1;
            @(negedge clk);
            a_i = 32'h40400000; b_i = 32'h3F800000; rnd_i = 2'd0; guard_i = 1'b1; issue_i = 1'b1;
            @(negedge clk);
            a_i = 32'h3F800000; b_i = 32'h40400000;
            for (int n = 1; n <= 36; n++) begin
                @(negedge clk);
                if (n == 14) b14 = busy_o;
                if (n == 15) b15 = busy_o;
                if (n == 16) begin
                    issue_i = 1'b0;
                    qidle = (q_o == '0);
                end
                if (done_o) begin
                    nds++;
                    if (d1 < 0) begin d1 = n; q1 = q_o; end
                    else begin d2 = n; q2 = q_o; end
                end
            end
            chk(b14 == 1'b1, "R2 busy at k+14", {31'b0, b14}, 32'h1);
            chk(b15 == 1'b0, "R2 free at k+15", {31'b0, b15}, 32'h0);
            chk(qidle, "R1 q_o zero outside strobe", {31'b0, qidle}, 32'h1);
            chk(d1 == 17, "R2 first done cycle", d1, 17);
            chk(q1 == 32'h40400000, "R2 first op kept", q1, 32'h40400000);
            chk(d2 == 33, "R2 second done cycle", d2, 33);
            chk(q2 == 32'h3EAAAAAB, "R2 second op result", q2, 32'h3EAAAAAB);
            chk(nds == 2, "R2 refused issues dropped", nds, 2);
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule